// File: doc/BRIEF.md
# Programmable Output Clock Divider with Observation Selector

This block sits after the oscillator stage of a clock synthesizer and turns a fast source clock into the block's output clock. Everything runs on one fast system clock `clk`. Each slower clock arrives as a one-cycle enable pulse. `src_en` and `ref_en` pulse once for every edge of their clock, rising and falling. `sclk_en` pulses once for each rising edge of the serial clock. `fb_tick` pulses once each time the external feedback divider completes a count. A 2-bit divide code sets the output ratio. Each output phase is a whole number of source edges, so the duty cycle is always exactly half.

A second output carries one of eight internal signals for test. The selection is made by a 3-bit code. The signals on offer are the serial-out bit of a neighbouring shift register, two constants, the reference divided by 16, the feedback divider output halved, the main output, a serial-clock loop divider, and the main output divided by four. The divide code, the test code and the loop divisor M are taken from the configuration pins only on a `cfg_load` clock. A new divide code is applied only at the next phase boundary, so a change never makes a short pulse.

Top module: `odiv_outdiv_top`

## Requirements
- R1: Divide code 2'b00 gives a ratio of 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 1. Every high phase and every low phase of the main divider lasts exactly `ratio` pulses of `src_en`, so the output period is `ratio` source periods and the duty cycle is 50%.
- R2: A new divide code never cuts the phase in progress short. That phase ends at the length it began with, and the new ratio applies from the following phase.
- R3: Test code 3'b010 shows the reference divided by 16. This signal toggles after every 16th `ref_en` pulse.
- R4: Test code 3'b000 passes `sr_sout`, 3'b001 drives 1, 3'b101 drives 0, and 3'b100 shows the main divider phase before any gating by output enable.
- R5: Test code 3'b011 shows the feedback divider output halved. It toggles on every `fb_tick` pulse.
- R6: Test code 3'b110 shows the serial clock divided by M and then halved. It toggles after every M `sclk_en` pulses. An M of 0 acts as 1. A new M applies from the next phase of this signal.
- R7: Test code 3'b111 shows the main output divided by 4. It toggles after every fourth edge of the main divider.
- R8: `fout` is registered. On each clock it equals the output-enable input ANDed with the main phase as it stood before that edge. While `oe` is low, `fout` is 0 from the next clock on. `test_out` does not depend on `oe`.
- R9: The divide code, test code and M are captured only on clocks where `cfg_load` is 1; pin changes at other times have no effect. After reset the divide code is 2'b00, the test code is 3'b000, M is 1, every divider phase is 0 and `fout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | One pulse per source clock edge |
| ref_en | input | 1 | One pulse per reference clock edge |
| fb_tick | input | 1 | One pulse per feedback divider completion |
| sclk_en | input | 1 | One pulse per serial clock rising edge |
| sr_sout | input | 1 | Serial-out bit of the configuration shift register |
| cfg_load | input | 1 | Capture strobe for the configuration pins |
| n_code_in | input | 2 | Output divide code |
| t_code_in | input | 3 | Test output select code |
| m_val_in | input | MW (9) | Loop divisor M for the serial-clock path |
| oe | input | 1 | Output enable for `fout` |
| fout | output | 1 | Divided main output clock |
| test_out | output | 1 | Selected observation signal |

## Verification
The hardest situation to reach from the pins is a divide-code change that lands in the middle of a long phase, above all a switch from ratio 8 to ratio 1. In that case the old phase must still run its full length before the new ratio takes over. The stimulus holds `src_en` high and captures ratio 8. It then loads ratio 1 a few cycles into a phase, and repeats this with the change landing at other offsets, while the main phase is watched through the test output. Random runs then change codes at random points while the enable trains run at random densities, and each cycle is compared with a reference model in the bench.

// File: rtl/odiv_pkg.sv
package odiv_pkg;

  localparam int MAIN_LW = 4;

  typedef enum logic [1:0] {
    NDIV_2 = 2'b00,
    NDIV_4 = 2'b01,
    NDIV_8 = 2'b10,
    NDIV_1 = 2'b11
  } ndiv_e;

  typedef enum logic [2:0] {
    TSEL_SHIFT = 3'b000,
    TSEL_HIGH  = 3'b001,
    TSEL_REF   = 3'b010,
    TSEL_FB    = 3'b011,
    TSEL_MAIN  = 3'b100,
    TSEL_LOW   = 3'b101,
    TSEL_SER   = 3'b110,
    TSEL_QTR   = 3'b111
  } tsel_e;

  // number of source edges per output phase for a divide code
  function automatic logic [MAIN_LW-1:0] ndiv_len(input logic [1:0] code);
    case (code)
      NDIV_2:  ndiv_len = MAIN_LW'(2);
      NDIV_4:  ndiv_len = MAIN_LW'(4);
      NDIV_8:  ndiv_len = MAIN_LW'(8);
      default: ndiv_len = MAIN_LW'(1);
    endcase
  endfunction

endpackage

// File: rtl/odiv_edge_div.sv
// Toggle divider: flips q after len enable pulses; the length is
// resampled only on the pulse that ends a phase.
module odiv_edge_div #(
  parameter int LW      = 4,
  parameter int RST_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] len_in,
  output logic          q,
  output logic          tgl
);

  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_q, len_d;
  logic          q_d;

  assign tgl = en && (cnt_q == (len_q - LW'(1)));

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    q_d   = q;
    if (en) begin
      if (tgl) begin
        cnt_d = '0;
        len_d = len_in;
        q_d   = ~q;
      end else begin
        cnt_d = cnt_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= LW'(RST_LEN);
      q     <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
      q     <= q_d;
    end
  end

  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q); // R1
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    len_q != '0); // R6
  AST_FLIP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> $past(en)); // R1
  AST_LEN_HELD_MID_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !tgl |=> $stable(len_q)); // R2

endmodule

// File: rtl/odiv_cfg_regs.sv
module odiv_cfg_regs #(
  parameter int MW    = 9,
  parameter int M_RST = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    n_in,
  input  logic [2:0]    t_in,
  input  logic [MW-1:0] m_in,
  output logic [1:0]    n_q,
  output logic [2:0]    t_q,
  output logic [MW-1:0] m_q
);

  logic [1:0]    n_d;
  logic [2:0]    t_d;
  logic [MW-1:0] m_d;

  always_comb begin
    n_d = n_q;
    t_d = t_q;
    m_d = m_q;
    if (load) begin
      n_d = n_in;
      t_d = t_in;
      m_d = m_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= 2'b00;
      t_q <= 3'b000;
      m_q <= MW'(M_RST);
    end else begin
      n_q <= n_d;
      t_q <= t_d;
      m_q <= m_d;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({n_q, t_q, m_q})); // R9

endmodule

// File: rtl/odiv_test_mux.sv
module odiv_test_mux
  import odiv_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       sr_sout,
  input  logic       ref_q,
  input  logic       fb_q,
  input  logic       main_q,
  input  logic       ser_q,
  input  logic       qtr_q,
  output logic       y
);

  logic [7:0] src;

  always_comb begin
    src             = '0;
    src[TSEL_SHIFT] = sr_sout;
    src[TSEL_HIGH]  = 1'b1;
    src[TSEL_REF]   = ref_q;
    src[TSEL_FB]    = fb_q;
    src[TSEL_MAIN]  = main_q;
    src[TSEL_LOW]   = 1'b0;
    src[TSEL_SER]   = ser_q;
    src[TSEL_QTR]   = qtr_q;
    y               = src[sel];
  end

endmodule

// File: rtl/odiv_outdiv_top.sv
module odiv_outdiv_top
  import odiv_pkg::*;
#(
  parameter int MW      = 9,
  parameter int M_RST   = 1,
  parameter int REF_DIV = 16,
  parameter int QTR_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_en,
  input  logic          ref_en,
  input  logic          fb_tick,
  input  logic          sclk_en,
  input  logic          sr_sout,
  input  logic          cfg_load,
  input  logic [1:0]    n_code_in,
  input  logic [2:0]    t_code_in,
  input  logic [MW-1:0] m_val_in,
  input  logic          oe,
  output logic          fout,
  output logic          test_out
);

  localparam int REF_LW = $clog2(REF_DIV + 1);
  localparam int QTR_LW = $clog2(QTR_DIV + 1);

  logic [1:0]    n_cfg;
  logic [2:0]    t_cfg;
  logic [MW-1:0] m_cfg;
  logic [MW-1:0] m_len;
  logic          main_q, main_tgl;
  logic          ref_q, ref_tgl;
  logic          fb_q, fb_tgl;
  logic          ser_q, ser_tgl;
  logic          qtr_q, qtr_tgl;
  logic          fout_d;

  odiv_cfg_regs #(.MW(MW), .M_RST(M_RST)) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .n_in(n_code_in), .t_in(t_code_in), .m_in(m_val_in),
    .n_q(n_cfg), .t_q(t_cfg), .m_q(m_cfg)
  );

  odiv_edge_div #(.LW(MAIN_LW), .RST_LEN(2)) main_div_i (
    .clk(clk), .rst_n(rst_n), .en(src_en), .len_in(ndiv_len(n_cfg)),
    .q(main_q), .tgl(main_tgl)
  );

  odiv_edge_div #(.LW(REF_LW), .RST_LEN(REF_DIV)) ref_div_i (
    .clk(clk), .rst_n(rst_n), .en(ref_en), .len_in(REF_LW'(REF_DIV)),
    .q(ref_q), .tgl(ref_tgl)
  );

  odiv_edge_div #(.LW(1), .RST_LEN(1)) fb_div_i (
    .clk(clk), .rst_n(rst_n), .en(fb_tick), .len_in(1'b1),
    .q(fb_q), .tgl(fb_tgl)
  );

  assign m_len = (m_cfg == '0) ? MW'(1) : m_cfg;

  odiv_edge_div #(.LW(MW), .RST_LEN((M_RST == 0) ? 1 : M_RST)) ser_div_i (
    .clk(clk), .rst_n(rst_n), .en(sclk_en), .len_in(m_len),
    .q(ser_q), .tgl(ser_tgl)
  );

  odiv_edge_div #(.LW(QTR_LW), .RST_LEN(QTR_DIV)) qtr_div_i (
    .clk(clk), .rst_n(rst_n), .en(main_tgl), .len_in(QTR_LW'(QTR_DIV)),
    .q(qtr_q), .tgl(qtr_tgl)
  );

  odiv_test_mux mux_i (
    .sel(t_cfg), .sr_sout(sr_sout), .ref_q(ref_q), .fb_q(fb_q),
    .main_q(main_q), .ser_q(ser_q), .qtr_q(qtr_q), .y(test_out)
  );

  always_comb begin
    fout_d = oe & main_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fout <= 1'b0;
    else        fout <= fout_d;
  end

  AST_OE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |=> !fout); // R8
  AST_QTR_ON_MAIN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (qtr_q != $past(qtr_q)) |-> (main_q != $past(main_q))); // R7
  AST_REF_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tgl |=> (ref_q != $past(ref_q))); // R3
  AST_FB_EACH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tick |=> (fb_q != $past(fb_q))); // R5
  AST_SER_ONLY_ON_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_tgl |=> $stable(ser_q)); // R6
  AST_FB_TGL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tgl == fb_tick); // R5

endmodule

// File: tb/odiv_outdiv_top_tb.sv
module odiv_outdiv_top_tb_top;

  localparam int MW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          src_en, ref_en, fb_tick, sclk_en, sr_sout, cfg_load, oe;
  logic [1:0]    n_code_in;
  logic [2:0]    t_code_in;
  logic [MW-1:0] m_val_in;
  logic          fout, test_out;

  always #10 clk = ~clk;

  odiv_outdiv_top #(.MW(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .ref_en(ref_en),
    .fb_tick(fb_tick), .sclk_en(sclk_en), .sr_sout(sr_sout),
    .cfg_load(cfg_load), .n_code_in(n_code_in), .t_code_in(t_code_in),
    .m_val_in(m_val_in), .oe(oe), .fout(fout), .test_out(test_out)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string ftag   = "R1";

  // reference model state
  bit          mm_q, rf_q, fb_q, sr_q, qt_q, fo_m;
  int          mm_cnt, mm_len, rf_cnt, sr_cnt, sr_len, qt_cnt;
  bit [1:0]    n_c;
  bit [2:0]    t_c;
  int          m_c;

  function automatic int n_ratio(input bit [1:0] n);
    case (n)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic bit exp_test(input bit [2:0] t, input bit so);
    case (t)
      3'b000: return so;
      3'b001: return 1'b1;
      3'b010: return rf_q;
      3'b011: return fb_q;
      3'b100: return mm_q;
      3'b101: return 1'b0;
      3'b110: return sr_q;
      default: return qt_q;
    endcase
  endfunction

  function automatic string test_tag(input bit [2:0] t);
    case (t)
      3'b010: return "R3";
      3'b011: return "R5";
      3'b110: return "R6";
      3'b111: return "R7";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    bit mt;
    if (!rst_n) begin
      mm_q = 0; rf_q = 0; fb_q = 0; sr_q = 0; qt_q = 0; fo_m = 0;
      mm_cnt = 0; mm_len = 2; rf_cnt = 0; sr_cnt = 0; sr_len = 1; qt_cnt = 0;
      n_c = 2'b00; t_c = 3'b000; m_c = 1;
    end else begin
      fo_m = oe & mm_q;
      mt = src_en && (mm_cnt == mm_len - 1);
      if (src_en) begin
        if (mt) begin mm_q = ~mm_q; mm_cnt = 0; mm_len = n_ratio(n_c); end
        else mm_cnt++;
      end
      if (mt) begin
        if (qt_cnt == 3) begin qt_q = ~qt_q; qt_cnt = 0; end else qt_cnt++;
      end
      if (ref_en) begin
        if (rf_cnt == 15) begin rf_q = ~rf_q; rf_cnt = 0; end else rf_cnt++;
      end
      if (fb_tick) fb_q = ~fb_q;
      if (sclk_en) begin
        if (sr_cnt == sr_len - 1) begin
          sr_q = ~sr_q; sr_cnt = 0; sr_len = (m_c == 0) ? 1 : m_c;
        end else sr_cnt++;
      end
      if (cfg_load) begin n_c = n_code_in; t_c = t_code_in; m_c = m_val_in; end
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(fout, fo_m, ftag);
    chk(test_out, exp_test(t_c, sr_sout), test_tag(t_c));
  endtask

  task automatic load_cfg(input bit [1:0] n, input bit [2:0] t, input int m);
    cfg_load = 1; n_code_in = n; t_code_in = t; m_val_in = MW'(m);
    cyc();
    cfg_load = 0;
  endtask

  task automatic rand_inputs(input bit allow_load);
    src_en  = $urandom_range(0, 1);
    ref_en  = $urandom_range(0, 1);
    fb_tick = ($urandom_range(0, 3) == 0);
    sclk_en = $urandom_range(0, 1);
    sr_sout = $urandom_range(0, 1);
    if ($urandom_range(0, 31) == 0) oe = ~oe;
    n_code_in = 2'($urandom_range(0, 3));
    t_code_in = 3'($urandom_range(0, 7));
    m_val_in  = MW'($urandom_range(0, 10));
    cfg_load  = allow_load && ($urandom_range(0, 40) == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; src_en = 0; ref_en = 0; fb_tick = 0; sclk_en = 0; sr_sout = 0;
    cfg_load = 0; oe = 1; n_code_in = 0; t_code_in = 0; m_val_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(fout, 1'b0, "R9");
    chk(test_out, 1'b0, "R9");
    sr_sout = 1;
    #1 chk(test_out, 1'b1, "R9");
    rst_n = 1;
    sr_sout = 0;

    // R1: every ratio with a dense source train, observed on both outputs
    for (int n = 0; n < 4; n++) begin
      ftag = "R1";
      load_cfg(2'(n), 3'b100, 1);
      src_en = 1;
      repeat (40) cyc();
      src_en = 0;
      repeat (2) cyc();
    end

    // R2: mid-phase code changes, 8 down to 1 and back, at several offsets
    ftag = "R2";
    for (int k = 1; k < 7; k++) begin
      load_cfg(2'b10, 3'b100, 1);
      src_en = 1;
      repeat (20 + k) cyc();
      load_cfg(2'b11, 3'b100, 1);
      repeat (5) cyc();
      load_cfg(2'b10, 3'b111, 1);
      repeat (k) cyc();
      load_cfg(2'b01, 3'b100, 1);
      repeat (30) cyc();
    end

    // R9: pins wiggle without the load strobe
    ftag = "R9";
    for (int i = 0; i < 60; i++) begin
      rand_inputs(1'b0);
      oe = 1;
      cyc();
    end

    // R8: output enable toggling while divider keeps running
    ftag = "R8";
    load_cfg(2'b00, 3'b100, 1);
    src_en = 1;
    for (int i = 0; i < 60; i++) begin
      oe = (i % 7) < 3;
      cyc();
    end
    oe = 1;

    // R6: serial path with M of 3, then M of 0
    ftag = "R1";
    load_cfg(2'b00, 3'b110, 3);
    for (int i = 0; i < 40; i++) begin sclk_en = $urandom_range(0, 1); cyc(); end
    load_cfg(2'b00, 3'b110, 0);
    for (int i = 0; i < 30; i++) begin sclk_en = $urandom_range(0, 1); cyc(); end

    // every test code with random traffic
    for (int t = 0; t < 8; t++) begin
      load_cfg(2'($urandom_range(0, 3)), 3'(t), $urandom_range(1, 6));
      for (int i = 0; i < 150; i++) begin
        rand_inputs(1'b0);
        cyc();
      end
    end

    // fully random mix
    ftag = "R1";
    for (int i = 0; i < 4000; i++) begin
      rand_inputs(1'b1);
      if (!oe) ftag = "R8"; else ftag = "R1";
      cyc();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule